// File: doc/BRIEF.md
# Lockable Thermal Protection Register Block

This block is the control and status register set of an on-die thermal monitor. A simple register bus reads and writes it: one address, a write strobe, write data and combinational read data. Software sets a critical temperature limit, a calibration slope and a hardware-shutdown enable. It also owns a single lock bit. The block turns each raw sensor sample into degrees with the slope. The result is readable as the current temperature. When that temperature rises above the limit while shutdown is enabled, the block raises a shutdown request.

Boot firmware programs the limit, the slope and the enable, then sets the lock. From then until the next reset, nothing that can change detection or response is writable. That covers the threshold, the conversion slope and the enable. The lock itself cannot be cleared by any write. The shutdown request is sticky: once raised it stays high until reset.

Top module: `thermal_guard_regs`

## Requirements
- R1: After reset the limit reads 125, the slope reads 25, and the lock bit, the shutdown enable, the current temperature and the shutdown output all read 0.
- R2: Register map, byte offsets:
  - 0x00: limit in bits [7:0].
  - 0x04: slope in bits [31:0].
  - 0x08: lock in bit 0.
  - 0x0C: shutdown enable in bit 1.
  - 0x10: current temperature in bits [7:0].
  - All other bits of these registers, and every other address, read as 0.
- R3: A write to 0x08 with bit 0 = 1 sets the lock. Writing 0, writing 1 again, or writing other bits has no effect on it, and only reset clears it.
- R4: While the lock is set, writes to the limit, the slope and the shutdown enable are dropped and their values hold. This includes a write in the cycle right after the lock write.
- R5: The current temperature becomes min(255, (raw × slope) >> 4) at the clock edge where the sample strobe is high. It holds otherwise. Writes to 0x10 are ignored.
- R6: The shutdown output rises one clock after the current temperature is strictly greater than the limit while the enable is set. An equal temperature does not trip it.
- R7: Once high, the shutdown output stays high until reset, even if the temperature falls or a lower sample arrives.
- R8: Before the lock is set, writes to the limit, the slope and the enable take effect at the write's clock edge and read back on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register byte address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| raw_vld | input | 1 | Raw sample strobe |
| raw_code | input | 12 | Raw sensor sample |
| shutdown_o | output | 1 | Sticky hardware shutdown request |

## Verification
The assertions check on every cycle the properties that hold between any two adjacent cycles:
- the lock never clears once set;
- the limit, slope and enable stay frozen while locked;
- the temperature holds when no sample arrives;
- the shutdown output never falls;
- each rise of the shutdown output follows a cycle where the enable was set and the temperature exceeded the limit.

Only the bench scenarios can show the rest:
- the conversion values, including saturation;
- the strict-versus-equal comparison;
- the reset values and the zeroed reserved bits;
- that a write one cycle after the lock write is really blocked;
- that ignored writes to the lock and to the temperature leave nothing changed.

// File: rtl/thermal_guard_pkg.sv
package thermal_guard_pkg;
   // byte offsets of the register map
   localparam int unsigned OFS_LIMIT = 'h00;
   localparam int unsigned OFS_SLOPE = 'h04;
   localparam int unsigned OFS_LOCK  = 'h08;
   localparam int unsigned OFS_SHDN  = 'h0C;
   localparam int unsigned OFS_TEMP  = 'h10;
   // field positions
   localparam int unsigned LOCK_BIT  = 0;
   localparam int unsigned EN_BIT    = 1;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_LIMIT,
      SEL_SLOPE,
      SEL_LOCK,
      SEL_SHDN,
      SEL_TEMP
   } reg_sel_e;
endpackage

// File: rtl/tg_lock_cell.sv
module tg_lock_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   output logic lock_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)       lock_q <= 1'b0;
      else if (set_req) lock_q <= 1'b1;
   end

   AST_LOCK_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q); // R3
endmodule

// File: rtl/tg_ctrl_regs.sv
module tg_ctrl_regs #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned TEMP_W    = 8,
   parameter int unsigned LIMIT_RST = 125,
   parameter int unsigned SLOPE_RST = 25,
   parameter int unsigned EN_POS    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              locked,
   input  logic              wr_limit,
   input  logic              wr_slope,
   input  logic              wr_shdn,
   input  logic [DATA_W-1:0] wdata,
   output logic [TEMP_W-1:0] limit_q,
   output logic [DATA_W-1:0] slope_q,
   output logic              shdn_en_q
);
   // every detection/response control shares one gate
   logic open_w;
   assign open_w = !locked;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         limit_q   <= TEMP_W'(LIMIT_RST);
         slope_q   <= DATA_W'(SLOPE_RST);
         shdn_en_q <= 1'b0;
      end else if (open_w) begin
         if (wr_limit) limit_q   <= wdata[TEMP_W-1:0];
         if (wr_slope) slope_q   <= wdata;
         if (wr_shdn)  shdn_en_q <= wdata[EN_POS];
      end
   end

   AST_LIMIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(limit_q)); // R4
   AST_SLOPE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(slope_q)); // R4
   AST_ENABLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(shdn_en_q)); // R4
endmodule

// File: rtl/tg_temp_convert.sv
module tg_temp_convert #(
   parameter int unsigned RAW_W      = 12,
   parameter int unsigned SLOPE_W    = 32,
   parameter int unsigned TEMP_W     = 8,
   parameter int unsigned FRAC_SHIFT = 4,
   parameter bit          SATURATE   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               smp_vld,
   input  logic [RAW_W-1:0]   smp_raw,
   input  logic [SLOPE_W-1:0] slope,
   output logic [TEMP_W-1:0]  temp_q
);
   localparam int unsigned PROD_W = RAW_W + SLOPE_W;

   logic [PROD_W-1:0] prod_w;
   logic [PROD_W-1:0] scaled_w;
   logic [TEMP_W-1:0] conv_w;

   assign prod_w   = PROD_W'(smp_raw) * PROD_W'(slope);
   assign scaled_w = prod_w >> FRAC_SHIFT;

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            if (|scaled_w[PROD_W-1:TEMP_W]) conv_w = '1;
            else                            conv_w = scaled_w[TEMP_W-1:0];
         end
      end else begin : g_wrap
         assign conv_w = scaled_w[TEMP_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       temp_q <= '0;
      else if (smp_vld) temp_q <= conv_w;
   end

   AST_TEMP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld |=> $stable(temp_q)); // R5
endmodule

// File: rtl/tg_trip_latch.sv
module tg_trip_latch #(
   parameter int unsigned TEMP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [TEMP_W-1:0] temp,
   input  logic [TEMP_W-1:0] limit,
   output logic              trip_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)                      trip_q <= 1'b0;
      else if (enable && temp > limit) trip_q <= 1'b1;
   end

   AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      trip_q |=> trip_q); // R7
   AST_TRIP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trip_q) |-> $past(enable && (temp > limit))); // R6
endmodule

// File: rtl/thermal_guard_regs.sv
module thermal_guard_regs
   import thermal_guard_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned TEMP_W     = 8,
   parameter int unsigned RAW_W      = 12,
   parameter int unsigned FRAC_SHIFT = 4,
   parameter int unsigned LIMIT_RST  = 125,
   parameter int unsigned SLOPE_RST  = 25,
   parameter bit          SATURATE   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              raw_vld,
   input  logic [RAW_W-1:0]  raw_code,
   output logic              shutdown_o
);
   generate
      if (ADDR_W < 5) begin : g_chk_addr
         $error("ADDR_W too small for register map");
      end
      if (TEMP_W > DATA_W || EN_BIT >= DATA_W) begin : g_chk_data
         $error("DATA_W too small for fields");
      end
      if (LIMIT_RST >= (1 << TEMP_W)) begin : g_chk_rst
         $error("LIMIT_RST does not fit TEMP_W");
      end
   endgenerate

   reg_sel_e          sel_w;
   logic              lock_q;
   logic [TEMP_W-1:0] limit_q;
   logic [DATA_W-1:0] slope_q;
   logic              shdn_en_q;
   logic [TEMP_W-1:0] temp_q;

   always_comb begin
      if      (reg_addr == ADDR_W'(OFS_LIMIT)) sel_w = SEL_LIMIT;
      else if (reg_addr == ADDR_W'(OFS_SLOPE)) sel_w = SEL_SLOPE;
      else if (reg_addr == ADDR_W'(OFS_LOCK))  sel_w = SEL_LOCK;
      else if (reg_addr == ADDR_W'(OFS_SHDN))  sel_w = SEL_SHDN;
      else if (reg_addr == ADDR_W'(OFS_TEMP))  sel_w = SEL_TEMP;
      else                                     sel_w = SEL_NONE;
   end

   tg_lock_cell u_lock (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_req (reg_we && sel_w == SEL_LOCK && reg_wdata[LOCK_BIT]),
      .lock_q  (lock_q)
   );

   tg_ctrl_regs #(
      .DATA_W    (DATA_W),
      .TEMP_W    (TEMP_W),
      .LIMIT_RST (LIMIT_RST),
      .SLOPE_RST (SLOPE_RST),
      .EN_POS    (EN_BIT)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .locked    (lock_q),
      .wr_limit  (reg_we && sel_w == SEL_LIMIT),
      .wr_slope  (reg_we && sel_w == SEL_SLOPE),
      .wr_shdn   (reg_we && sel_w == SEL_SHDN),
      .wdata     (reg_wdata),
      .limit_q   (limit_q),
      .slope_q   (slope_q),
      .shdn_en_q (shdn_en_q)
   );

   tg_temp_convert #(
      .RAW_W      (RAW_W),
      .SLOPE_W    (DATA_W),
      .TEMP_W     (TEMP_W),
      .FRAC_SHIFT (FRAC_SHIFT),
      .SATURATE   (SATURATE)
   ) u_conv (
      .clk     (clk),
      .rst_n   (rst_n),
      .smp_vld (raw_vld),
      .smp_raw (raw_code),
      .slope   (slope_q),
      .temp_q  (temp_q)
   );

   tg_trip_latch #(
      .TEMP_W (TEMP_W)
   ) u_trip (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (shdn_en_q),
      .temp   (temp_q),
      .limit  (limit_q),
      .trip_q (shutdown_o)
   );

   always_comb begin
      reg_rdata = '0;
      case (sel_w)
         SEL_LIMIT: reg_rdata = DATA_W'(limit_q);
         SEL_SLOPE: reg_rdata = slope_q;
         SEL_LOCK:  reg_rdata[LOCK_BIT] = lock_q;
         SEL_SHDN:  reg_rdata[EN_BIT]   = shdn_en_q;
         SEL_TEMP:  reg_rdata = DATA_W'(temp_q);
         default:   reg_rdata = '0;
      endcase
   end

   AST_LOCK_BLOCKS_LIMIT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && reg_we && sel_w == SEL_LIMIT) |=> $stable(limit_q)); // R4
   AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_w == SEL_NONE) |-> (reg_rdata == '0)); // R2
endmodule

// File: tb/tb_thermal_guard_regs.sv
module tb_thermal_guard_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        raw_vld = 1'b0;
   logic [11:0] raw_code = '0;
   logic        shutdown_o;

   always #10 clk = ~clk; // 50 MHz

   thermal_guard_regs dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .raw_vld(raw_vld),
      .raw_code(raw_code), .shutdown_o(shutdown_o)
   );

   typedef struct {
      bit          is_port;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // monitor: compares each expected item a quarter period after it was issued
   initial begin
      forever begin
         @(negedge clk);
         #5;
         if (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = q.pop_front();
            act = it.is_port ? {31'd0, shutdown_o} : reg_rdata;
            n_vec++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic idle();
      @(negedge clk);
      reg_we = 1'b0; raw_vld = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      raw_vld = 1'b0; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
      item_t it;
      @(negedge clk);
      raw_vld = 1'b0; reg_we = 1'b0; reg_addr = a;
      it.is_port = 1'b0; it.exp = e; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic chk_sd(input logic e, input string tag);
      item_t it;
      @(negedge clk);
      raw_vld = 1'b0; reg_we = 1'b0;
      it.is_port = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
      q.push_back(it);
   endtask

   // sample, then one idle cycle so temperature and trip both settle
   task automatic sample(input logic [11:0] r);
      @(negedge clk);
      reg_we = 1'b0; raw_vld = 1'b1; raw_code = r;
      idle();
   endtask

   function automatic logic [31:0] conv(input int raw, input int slope);
      longint v;
      v = (longint'(raw) * longint'(slope)) >>> 4;
      return (v > 255) ? 32'd255 : 32'(v);
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state
      rd(8'h00, 32'd125, "R1 limit");
      rd(8'h04, 32'd25,  "R1 slope");
      rd(8'h08, 32'd0,   "R1 lock");
      rd(8'h0C, 32'd0,   "R1 enable");
      rd(8'h10, 32'd0,   "R1 temp");
      chk_sd(1'b0, "R1 shutdown");
      // map, reserved bits, writes before lock
      rd(8'h14, 32'd0, "R2 unmapped 0x14");
      rd(8'h40, 32'd0, "R2 unmapped 0x40");
      wr(8'h00, 32'hFFFF_FF50);
      rd(8'h00, 32'h50, "R2 R8 limit reserved bits");
      wr(8'h0C, 32'hFFFF_FFFF);
      rd(8'h0C, 32'h2, "R2 R8 enable bit1 only");
      wr(8'h0C, 32'h0);
      rd(8'h0C, 32'h0, "R8 enable cleared");
      wr(8'h04, 32'd32);
      rd(8'h04, 32'd32, "R8 slope");
      wr(8'h10, 32'hAB);
      rd(8'h10, 32'd0, "R5 temp write ignored");
      // conversion
      sample(12'd40);
      rd(8'h10, conv(40, 32), "R5 conversion");
      sample(12'd200);
      rd(8'h10, conv(200, 32), "R5 saturation");
      chk_sd(1'b0, "R6 no trip while disabled");
      // equal temperature does not trip
      wr(8'h00, 32'd100);
      sample(12'd50);
      rd(8'h10, conv(50, 32), "R5 temp 100");
      wr(8'h0C, 32'h2);
      idle();
      chk_sd(1'b0, "R6 equal does not trip");
      // lock behaviour
      wr(8'h08, 32'hFFFF_FFFE);
      rd(8'h08, 32'd0, "R3 bit0 zero no lock");
      wr(8'h08, 32'h1);
      wr(8'h00, 32'h10);
      rd(8'h08, 32'd1, "R3 lock set");
      rd(8'h00, 32'd100, "R4 write right after lock");
      wr(8'h04, 32'd7);
      rd(8'h04, 32'd32, "R4 slope locked");
      wr(8'h0C, 32'h0);
      rd(8'h0C, 32'h2, "R4 enable locked");
      wr(8'h08, 32'h0);
      rd(8'h08, 32'd1, "R3 write 0 ignored");
      wr(8'h08, 32'hFFFF_FFFE);
      rd(8'h08, 32'd1, "R3 reserved write ignored");
      wr(8'h08, 32'h1);
      rd(8'h08, 32'd1, "R3 rewrite 1");
      // trip and stickiness
      sample(12'd51);
      chk_sd(1'b1, "R6 trip above limit");
      sample(12'd10);
      rd(8'h10, conv(10, 32), "R7 temp fell");
      chk_sd(1'b1, "R7 sticky");
      // reset clears everything
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      chk_sd(1'b0, "R7 cleared by reset");
      rd(8'h08, 32'd0, "R3 lock cleared by reset");
      rd(8'h00, 32'd125, "R1 limit after reset");
      repeat (3) idle();
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule